// File: doc/BRIEF.md
# PCIe Configuration Access Router

This block sits between a processor-side configuration request port and the register spaces of a PCIe root port. Each request names a bus, device, function and register offset, a size and a direction. A request for bus 0 is sent straight to the root port's own register space. A request for any other bus first loads a routing word that names the target, then goes to a remote window. The remote window sits at a fixed distance above the local space base. The remote side may take any number of cycles to answer, and it may report that no device responded.

The router aligns the register offset to a dword. For narrow writes it places the data into the correct byte lanes and raises the matching byte enables. For narrow reads it extracts the addressed byte or halfword from the returned dword. It chooses Type 0 or Type 1 in the routing word: bus 1 is handled as the directly attached secondary bus and uses Type 0. A missing target never surfaces as a bus error. The router completes the access with a dedicated status code and all-ones data instead.

Only one remote access can be outstanding. Local accesses keep flowing while a remote access waits. When a local and a remote completion land together, the router orders them on its single response port.

Top module: `cfg_access_router`

## Requirements
- R1: After reset `req_ready` is 1, `loc_req`, `rem_req` and `rsp_valid` are 0 and `rem_setup` is 0.
- R2: A request with bus 0 raises `loc_req` for one cycle, starting the cycle after acceptance, with `cfg_addr` equal to the register offset with bits 1:0 cleared, and leaves `rem_setup` unchanged.
- R3: A request with a nonzero bus loads `rem_setup` with the bus in bits 23:16, the device in bits 12:8 and the function in bits 2:0, and all other bits 0 except bit 24. Bit 24 is 1 (Type 1) only when the bus is greater than 1, so bus 1 gives 0 (Type 0).
- R4: A request with a nonzero bus raises `rem_req` for one cycle, starting the cycle after acceptance, with `cfg_addr` equal to 0x1000 plus the dword-aligned register offset.
- R5: Size codes are 0 = byte, 1 = halfword, 2 or 3 = dword. A byte at offset bits 1:0 = k drives `cfg_be` bit k and write data in bits 8k+7:8k. A halfword drives `cfg_be` 0011 or 1100 as offset bit 1 selects, with data in the matching half. A dword drives 1111.
- R6: A read returns the addressed byte or halfword, taken from the dword at the lanes of R5, zero-extended in `rsp_rdata`. A dword read returns the whole dword. Writes return 0.
- R7: A remote completion with `rem_absent` set gives `rsp_rdata` = 0xFFFFFFFF and `rsp_status` = 1. Every other completion gives `rsp_status` = 0.
- R8: While a remote access is outstanding, `req_ready` is 0 for a request with a nonzero bus and 1 for a bus 0 request.
- R9: A local result is delivered on `rsp_valid` in the cycle after `loc_req`. A remote result is delivered in the cycle after `rem_done`, with `rsp_remote` = 1.
- R10: If `rem_done` arrives in a cycle where `loc_req` is high, the local result is delivered first. The remote result follows in the next cycle, and `req_ready` is 0 until it has been delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Request accepted at the next edge when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_reg | input | 12 | Register byte offset |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, right-aligned |
| cfg_write | output | 1 | Direction of the issued access |
| cfg_addr | output | 13 | Byte address into the register space |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| loc_req | output | 1 | Local register space strobe |
| loc_rdata | input | 32 | Local read dword, valid while `loc_req` is high |
| rem_req | output | 1 | Remote window strobe |
| rem_setup | output | 32 | Routing word for the remote target |
| rem_done | input | 1 | Remote access completed |
| rem_absent | input | 1 | Remote target did not respond |
| rem_rdata | input | 32 | Remote read dword, valid with `rem_done` |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | 32 | Response data |
| rsp_status | output | 2 | 0 = normal, 1 = target absent |
| rsp_remote | output | 1 | Response belongs to a remote access |

## Verification
The two functions that can fall in the same cycle are completing a local access and finishing the outstanding remote access. The bench provokes the overlap by leaving a remote access open, issuing a bus 0 read, and raising `rem_done` in exactly the cycle where `loc_req` is high. It judges the outcome on the ports. The local data must appear first with `rsp_remote` low. `req_ready` must stay low for one cycle. The held remote data must then appear with `rsp_remote` high, and nothing may be lost or duplicated. A separate case drives a second remote request against the open one, confirms the stall, and confirms that a bus 0 request still passes.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
    localparam int DATA_W         = 32;
    localparam int BE_W           = DATA_W / 8;
    localparam int OFF_W          = $clog2(BE_W);
    localparam int SETUP_W        = 32;
    localparam int SETUP_BUS_LSB  = 16;
    localparam int SETUP_DEV_LSB  = 8;
    localparam int SETUP_FUNC_LSB = 0;
    localparam int SETUP_TYPE_BIT = 24;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } cfg_size_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'b00,
        ST_ABSENT = 2'b01
    } cfg_status_e;

    typedef struct packed {
        cfg_size_e        size;
        logic [OFF_W-1:0] off;
        logic             write;
    } cfg_ctx_t;
endpackage

// File: rtl/cfgr_setup_gen.sv
module cfgr_setup_gen
    import cfgr_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FUNC_W = 3
) (
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEV_W-1:0]   dev,
    input  logic [FUNC_W-1:0]  func,
    output logic               is_remote,
    output logic [SETUP_W-1:0] setup_word
);
    logic type1;

    always_comb begin
        is_remote  = (bus != '0);
        type1      = (bus > BUS_W'(1));
        setup_word = '0;
        setup_word[SETUP_BUS_LSB  +: BUS_W]  = bus;
        setup_word[SETUP_DEV_LSB  +: DEV_W]  = dev;
        setup_word[SETUP_FUNC_LSB +: FUNC_W] = func;
        setup_word[SETUP_TYPE_BIT]           = type1;
    end
endmodule

// File: rtl/cfgr_lane_place.sv
module cfgr_lane_place
    import cfgr_pkg::*;
(
    input  cfg_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] lane_wdata
);
    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: be[i] = (OFF_W'(i) == off);
                SZ_HALF: be[i] = (OFF_W'(i) >> 1) == (off >> 1);
                default: be[i] = 1'b1;
            endcase
        end
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: lane_wdata = {{(DATA_W-8){1'b0}}, wdata[7:0]} << {off, 3'b000};
            SZ_HALF: lane_wdata = {{(DATA_W-16){1'b0}}, wdata[15:0]} << {off[OFF_W-1], 4'b0000};
            default: lane_wdata = wdata;
        endcase
    end
endmodule

// File: rtl/cfgr_extract.sv
module cfgr_extract
    import cfgr_pkg::*;
(
    input  cfg_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] dword,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] by_byte;
    logic [DATA_W-1:0] by_half;

    always_comb begin
        by_byte = dword >> {off, 3'b000};
        by_half = dword >> {off[OFF_W-1], 4'b0000};
        unique case (size)
            SZ_BYTE: value = {{(DATA_W-8){1'b0}}, by_byte[7:0]};
            SZ_HALF: value = {{(DATA_W-16){1'b0}}, by_half[15:0]};
            default: value = dword;
        endcase
    end
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
    import cfgr_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int DEV_W       = 5,
    parameter int FUNC_W      = 3,
    parameter int REG_W       = 12,
    parameter int REMOTE_BASE = 'h1000,
    localparam int ADDR_W     = $clog2(REMOTE_BASE + (1 << REG_W))
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [BUS_W-1:0]    req_bus,
    input  logic [DEV_W-1:0]    req_dev,
    input  logic [FUNC_W-1:0]   req_func,
    input  logic [REG_W-1:0]    req_reg,
    input  logic [1:0]          req_size,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                cfg_write,
    output logic [ADDR_W-1:0]   cfg_addr,
    output logic [BE_W-1:0]     cfg_be,
    output logic [DATA_W-1:0]   cfg_wdata,
    output logic                loc_req,
    input  logic [DATA_W-1:0]   loc_rdata,
    output logic                rem_req,
    output logic [SETUP_W-1:0]  rem_setup,
    input  logic                rem_done,
    input  logic                rem_absent,
    input  logic [DATA_W-1:0]   rem_rdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [1:0]          rsp_status,
    output logic                rsp_remote
);
    typedef struct packed {
        logic               cfg_write;
        logic [ADDR_W-1:0]  cfg_addr;
        logic [BE_W-1:0]    cfg_be;
        logic [DATA_W-1:0]  cfg_wdata;
        logic               loc_req;
        logic               rem_req;
        logic [SETUP_W-1:0] setup;
        logic               rem_busy;
        cfg_ctx_t           loc_ctx;
        cfg_ctx_t           rem_ctx;
        logic               hold_valid;
        logic [DATA_W-1:0]  hold_data;
        cfg_status_e        hold_status;
        logic               rsp_valid;
        logic [DATA_W-1:0]  rsp_data;
        cfg_status_e        rsp_status;
        logic               rsp_remote;
    } state_t;

    state_t st_d, st_q;

    cfg_size_e          size_in;
    logic [REG_W-1:0]   aligned_reg;
    logic               is_remote;
    logic [SETUP_W-1:0] setup_word;
    logic [BE_W-1:0]    be_in;
    logic [DATA_W-1:0]  lane_wdata;
    logic [DATA_W-1:0]  loc_value;
    logic [DATA_W-1:0]  rem_value;
    logic [DATA_W-1:0]  loc_result;
    logic [DATA_W-1:0]  rem_result;
    cfg_status_e        rem_stat;
    logic               rem_finish;
    logic               accept;

    assign size_in     = cfg_size_e'(req_size);
    assign aligned_reg = {req_reg[REG_W-1:OFF_W], {OFF_W{1'b0}}};

    cfgr_setup_gen #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W)) setup_i (
        .bus        (req_bus),
        .dev        (req_dev),
        .func       (req_func),
        .is_remote  (is_remote),
        .setup_word (setup_word)
    );

    cfgr_lane_place lane_i (
        .size       (size_in),
        .off        (req_reg[OFF_W-1:0]),
        .wdata      (req_wdata),
        .be         (be_in),
        .lane_wdata (lane_wdata)
    );

    cfgr_extract loc_ext_i (
        .size  (st_q.loc_ctx.size),
        .off   (st_q.loc_ctx.off),
        .dword (loc_rdata),
        .value (loc_value)
    );

    cfgr_extract rem_ext_i (
        .size  (st_q.rem_ctx.size),
        .off   (st_q.rem_ctx.off),
        .dword (rem_rdata),
        .value (rem_value)
    );

    always_comb begin
        req_ready  = !st_q.hold_valid && !(is_remote && st_q.rem_busy);
        accept     = req_valid && req_ready;
        rem_finish = rem_done && st_q.rem_busy && !st_q.hold_valid;
        loc_result = st_q.loc_ctx.write ? '0 : loc_value;
        rem_result = rem_absent ? '1 : (st_q.rem_ctx.write ? '0 : rem_value);
        rem_stat   = rem_absent ? ST_ABSENT : ST_OK;

        st_d            = st_q;
        st_d.loc_req    = 1'b0;
        st_d.rem_req    = 1'b0;
        st_d.rsp_valid  = 1'b0;
        st_d.rsp_remote = 1'b0;

        // Response ordering: local first, then held remote, then fresh remote
        if (st_q.loc_req) begin
            st_d.rsp_valid  = 1'b1;
            st_d.rsp_data   = loc_result;
            st_d.rsp_status = ST_OK;
            if (rem_finish) begin
                st_d.hold_valid  = 1'b1;
                st_d.hold_data   = rem_result;
                st_d.hold_status = rem_stat;
            end
        end else if (st_q.hold_valid) begin
            st_d.rsp_valid  = 1'b1;
            st_d.rsp_remote = 1'b1;
            st_d.rsp_data   = st_q.hold_data;
            st_d.rsp_status = st_q.hold_status;
            st_d.hold_valid = 1'b0;
            st_d.rem_busy   = 1'b0;
        end else if (rem_finish) begin
            st_d.rsp_valid  = 1'b1;
            st_d.rsp_remote = 1'b1;
            st_d.rsp_data   = rem_result;
            st_d.rsp_status = rem_stat;
            st_d.rem_busy   = 1'b0;
        end

        if (accept) begin
            st_d.cfg_write = req_write;
            st_d.cfg_be    = be_in;
            st_d.cfg_wdata = lane_wdata;
            if (is_remote) begin
                st_d.cfg_addr      = ADDR_W'(REMOTE_BASE) + ADDR_W'(aligned_reg);
                st_d.rem_req       = 1'b1;
                st_d.rem_busy      = 1'b1;
                st_d.setup         = setup_word;
                st_d.rem_ctx.size  = size_in;
                st_d.rem_ctx.off   = req_reg[OFF_W-1:0];
                st_d.rem_ctx.write = req_write;
            end else begin
                st_d.cfg_addr      = ADDR_W'(aligned_reg);
                st_d.loc_req       = 1'b1;
                st_d.loc_ctx.size  = size_in;
                st_d.loc_ctx.off   = req_reg[OFF_W-1:0];
                st_d.loc_ctx.write = req_write;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.hold_status <= ST_OK;
            st_q.rsp_status  <= ST_OK;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_write  = st_q.cfg_write;
    assign cfg_addr   = st_q.cfg_addr;
    assign cfg_be     = st_q.cfg_be;
    assign cfg_wdata  = st_q.cfg_wdata;
    assign loc_req    = st_q.loc_req;
    assign rem_req    = st_q.rem_req;
    assign rem_setup  = st_q.setup;
    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_rdata  = st_q.rsp_data;
    assign rsp_status = st_q.rsp_status;
    assign rsp_remote = st_q.rsp_remote;
endmodule

// File: rtl/cfg_access_router_chk.sv
module cfg_access_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        loc_req,
    input logic        rem_req,
    input logic        cfg_write,
    input logic [12:0] cfg_addr,
    input logic [3:0]  cfg_be,
    input logic [31:0] rem_setup,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic [1:0]  rsp_status,
    input logic        rsp_remote
);
    logic [1:0] rem_open;

    always_ff @(posedge clk) begin
        if (!rst_n) rem_open <= '0;
        else        rem_open <= rem_open + 2'(rem_req) - 2'(rsp_valid && rsp_remote);
    end

    // R2
    setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rem_req |-> $stable(rem_setup));
    // R3
    type_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rem_req |-> (rem_setup[24] == (rem_setup[23:16] > 8'd1)) && (rem_setup[23:16] != 8'd0));
    // R4
    window_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rem_req |-> cfg_addr[12] && (cfg_addr[1:0] == 2'b00));
    // R2
    local_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req |-> !cfg_addr[12] && (cfg_addr[1:0] == 2'b00) && !rem_req);
    // R5
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((loc_req || rem_req) && cfg_write) |->
            ($countones(cfg_be) == 1 || cfg_be == 4'b0011 || cfg_be == 4'b1100 || cfg_be == 4'b1111));
    // R7
    absent_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b01) |-> (rsp_rdata == 32'hFFFF_FFFF) && rsp_remote);
    // R8
    single_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rem_req |-> (rem_open == 2'd0));
    // R9
    local_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req |=> rsp_valid && !rsp_remote);
endmodule

bind cfg_access_router cfg_access_router_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .loc_req    (loc_req),
    .rem_req    (rem_req),
    .cfg_write  (cfg_write),
    .cfg_addr   (cfg_addr),
    .cfg_be     (cfg_be),
    .rem_setup  (rem_setup),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_status (rsp_status),
    .rsp_remote (rsp_remote)
);

// File: tb/cfg_access_router_tb_top.sv
`timescale 1ns/100ps
module cfg_access_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [11:0] req_reg = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        cfg_write;
    logic [12:0] cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        loc_req;
    logic [31:0] loc_rdata = '0;
    logic        rem_req;
    logic [31:0] rem_setup;
    logic        rem_done = 1'b0;
    logic        rem_absent = 1'b0;
    logic [31:0] rem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_status;
    logic        rsp_remote;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_access_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
        .req_reg(req_reg), .req_size(req_size), .req_wdata(req_wdata),
        .cfg_write(cfg_write), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .loc_req(loc_req), .loc_rdata(loc_rdata),
        .rem_req(rem_req), .rem_setup(rem_setup),
        .rem_done(rem_done), .rem_absent(rem_absent), .rem_rdata(rem_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
        .rsp_remote(rsp_remote)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                         input logic [2:0] fn, input logic [11:0] rg, input logic [1:0] sz,
                         input logic [31:0] wd);
        req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
        req_func = fn; req_reg = rg; req_size = sz; req_wdata = wd;
    endtask

    task automatic t_reset();
        check("R1 ready", 32'(req_ready), 32'd1);
        check("R1 loc_req", 32'(loc_req), 32'd0);
        check("R1 rem_req", 32'(rem_req), 32'd0);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 setup", rem_setup, 32'd0);
    endtask

    task automatic t_local_read(input logic [11:0] rg, input logic [1:0] sz,
                                input logic [31:0] dw, input logic [31:0] exp);
        logic [31:0] setup_before;
        @(negedge clk);
        setup_before = rem_setup;
        drive(1'b0, 8'd0, 5'd3, 3'd1, rg, sz, 32'd0);
        loc_rdata = dw;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 loc_req", 32'(loc_req), 32'd1);
        check("R2 addr", 32'(cfg_addr), {20'd0, rg[11:2], 2'b00});
        check("R2 setup untouched", rem_setup, setup_before);
        @(negedge clk);
        check("R9 local rsp_valid", 32'(rsp_valid), 32'd1);
        check("R6 local read data", rsp_rdata, exp);
        check("R7 local status", 32'(rsp_status), 32'd0);
    endtask

    task automatic t_local_write(input logic [11:0] rg, input logic [1:0] sz,
                                 input logic [31:0] wd, input logic [3:0] ebe,
                                 input logic [31:0] ewd);
        @(negedge clk);
        drive(1'b1, 8'd0, 5'd0, 3'd0, rg, sz, wd);
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 write flag", 32'(cfg_write), 32'd1);
        check("R5 byte enables", 32'(cfg_be), 32'(ebe));
        check("R5 lane data", cfg_wdata, ewd);
        @(negedge clk);
        check("R6 write returns zero", rsp_rdata, 32'd0);
    endtask

    task automatic t_remote(input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn,
                            input logic [11:0] rg, input logic [1:0] sz, input logic absent,
                            input logic [31:0] dw, input logic [31:0] esetup,
                            input logic [31:0] edata, input logic [1:0] est);
        @(negedge clk);
        drive(1'b0, bus, dev, fn, rg, sz, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 rem_req", 32'(rem_req), 32'd1);
        check("R3 setup word", rem_setup, esetup);
        check("R4 window addr", 32'(cfg_addr), 32'h1000 + {20'd0, rg[11:2], 2'b00});
        @(negedge clk);
        @(negedge clk);
        check("R9 no early rsp", 32'(rsp_valid), 32'd0);
        rem_done = 1'b1; rem_absent = absent; rem_rdata = dw;
        @(negedge clk);
        rem_done = 1'b0; rem_absent = 1'b0;
        check("R9 remote rsp", {30'd0, rsp_valid, rsp_remote}, 32'd3);
        check("R6 R7 remote data", rsp_rdata, edata);
        check("R7 remote status", 32'(rsp_status), 32'(est));
    endtask

    task automatic t_stall_and_collide();
        @(negedge clk);
        drive(1'b0, 8'd2, 5'd1, 3'd0, 12'h040, 2'd2, 32'd0);
        @(negedge clk);
        check("R4 open remote", 32'(rem_req), 32'd1);
        drive(1'b0, 8'd4, 5'd2, 3'd0, 12'h044, 2'd2, 32'd0);
        #1;
        check("R8 remote stalled", 32'(req_ready), 32'd0);
        @(negedge clk);
        check("R8 no second rem_req", 32'(rem_req), 32'd0);
        drive(1'b0, 8'd0, 5'd0, 3'd0, 12'h008, 2'd2, 32'd0);
        loc_rdata = 32'h1111_2222;
        #1;
        check("R8 local passes", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 loc_req", 32'(loc_req), 32'd1);
        rem_done = 1'b1; rem_rdata = 32'hCAFE_0042;
        @(negedge clk);
        rem_done = 1'b0;
        check("R10 local first", {30'd0, rsp_valid, rsp_remote}, 32'd2);
        check("R10 local data", rsp_rdata, 32'h1111_2222);
        drive(1'b0, 8'd0, 5'd0, 3'd0, 12'h00C, 2'd2, 32'd0);
        #1;
        check("R10 ready low while held", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 remote second", {30'd0, rsp_valid, rsp_remote}, 32'd3);
        check("R10 remote data", rsp_rdata, 32'hCAFE_0042);
        check("R10 no local issued", 32'(loc_req), 32'd0);
        @(negedge clk);
        check("R10 single delivery", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_local_read(12'h013, 2'd0, 32'hDDCC_BBAA, 32'h0000_00DD);
        t_local_read(12'h012, 2'd1, 32'hDDCC_BBAA, 32'h0000_DDCC);
        t_local_read(12'h011, 2'd2, 32'hDDCC_BBAA, 32'hDDCC_BBAA);
        t_local_write(12'h005, 2'd0, 32'hFFFF_FF5A, 4'b0010, 32'h0000_5A00);
        t_local_write(12'h00E, 2'd1, 32'hFFFF_1234, 4'b1100, 32'h1234_0000);
        t_local_write(12'h020, 2'd3, 32'h89AB_CDEF, 4'b1111, 32'h89AB_CDEF);
        t_remote(8'd5, 5'd3, 3'd2, 12'h101, 2'd0, 1'b0, 32'h4433_2211, 32'h0105_0302, 32'h0000_0022, 2'd0);
        t_remote(8'd1, 5'd31, 3'd7, 12'h00A, 2'd1, 1'b0, 32'h4433_2211, 32'h0001_1F07, 32'h0000_4433, 2'd0);
        t_local_read(12'h000, 2'd2, 32'h5555_AAAA, 32'h5555_AAAA);
        t_remote(8'd200, 5'd0, 3'd0, 12'hFFC, 2'd2, 1'b1, 32'h0000_0000, 32'h01C8_0000, 32'hFFFF_FFFF, 2'd1);
        t_remote(8'd2, 5'd0, 3'd0, 12'h003, 2'd0, 1'b1, 32'h1234_5678, 32'h0102_0000, 32'hFFFF_FFFF, 2'd1);
        t_stall_and_collide();
        t_remote(8'd4, 5'd2, 3'd0, 12'h044, 2'd2, 1'b0, 32'h0BAD_F00D, 32'h0104_0200, 32'h0BAD_F00D, 2'd0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule